// File: doc/BRIEF.md
# Prioritized Interrupt Mask Controller

This block collects up to 32 level-sensitive interrupt sources, masks them with a per-source enable bit, weights each with a 4-bit priority, and presents the CPU with a single encoded interrupt level: the highest priority among sources that are asserted, enabled and given a non-zero priority. The index of the winning source is presented beside the level.

Software reaches the block through a word-addressed register bus. Enable bits are set through one register and cleared through another, so no read-modify-write is ever needed to change the mask. Priorities are packed eight fields to a 32-bit word. Two read-only words show the raw source inputs and the masked requests.

A typical start-up writes all ones to the clear register and then writes the priority words. Individual sources are then enabled as their handlers are installed. Read data appears on `bus_rdata` in the cycle after the read strobe. The level and source outputs are registered and follow a change of state by one clock.

Top module: `pimc_top`

## Requirements
- R1: After reset every enable bit and every priority field is zero, `irq_level` and `irq_src` are 0, and reading any register returns 0 while no source is asserted.
- R2: A write to word offset 0 sets each enable bit whose data bit is one. Enable bits whose data bit is zero keep their value.
- R3: A write to word offset 1 clears each enable bit whose data bit is one and leaves the others as they are. Writing all ones clears every enable.
- R4: A read of offset 0 or offset 1 returns the current enable vector, with bit n belonging to source n.
- R5: Priority words sit at offsets 4 to 7. Source n uses word 4+n/8, bits [4*(n%8)+3 : 4*(n%8)]. A read returns the fields last written.
- R6: A read of offset 2 returns the raw source vector. A read of offset 3 returns the request vector: source AND enable AND (priority field not zero).
- R7: One clock after the state changes, `irq_level` equals the largest priority among requesting sources. It is 0 when no source requests.
- R8: `irq_src` gives the lowest-numbered source among those that share the winning priority. It is 0 when `irq_level` is 0.
- R9: A source with priority 0 never requests, even when it is enabled and asserted.
- R10: Sources are level-sensitive. The level holds while the source stays high and drops one clock after it falls, with no latching.
- R11: Writes to offsets 2, 3 and 8 to 15 change no state. Reads of offsets 8 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears the next cycle |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_i | input | 32 | Level-sensitive interrupt sources |
| irq_level | output | 4 | Encoded level of the winning request (0 = none) |
| irq_src | output | 5 | Index of the winning source |

## Verification
The hardest case to reach is a tie. Two or more requesting sources must hold the same top priority, and a lower-priority request must be pending underneath them. The stimulus programs two neighbouring sources to equal priority inside one packed word and keeps a third source at a lower value. It then drops the sources one at a time, so the winner moves first to the higher index and then to the lower-priority source. Random rounds then mix priority words, enables and source patterns, and a bench model searches the priorities from the highest value downward to find the expected result.

// File: rtl/pimc_pkg.sv
package pimc_pkg;
  // word offsets of the register file
  localparam int OFF_ENSET = 0;
  localparam int OFF_ENCLR = 1;
  localparam int OFF_RAW   = 2;
  localparam int OFF_REQ   = 3;
  localparam int OFF_PRIO0 = 4;

  // which priority word holds source n
  function automatic int fld_word(input int n, input int per_word);
    return n / per_word;
  endfunction

  // lowest bit of source n's field inside its word
  function automatic int fld_lsb(input int n, input int per_word, input int pw);
    return (n % per_word) * pw;
  endfunction
endpackage

// File: rtl/pimc_regs.sv
module pimc_regs #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic [NUM_SRC-1:0]             src_i,
  input  logic [NUM_SRC-1:0]             req_i,
  output logic [NUM_SRC-1:0]             en_o,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
  output logic [DATA_W-1:0]              rdata_o
);
  import pimc_pkg::*;
  localparam int SPW       = DATA_W / PRIO_W;
  localparam int NUM_PWORD = (NUM_SRC + SPW - 1) / SPW;

  logic [NUM_SRC-1:0]             en_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]             set_m, clr_m;
  logic [DATA_W-1:0]              pword [NUM_PWORD];
  logic [DATA_W-1:0]              rdata_d, rdata_q;
  int                             aidx;

  assign aidx  = int'(bus_addr);
  assign set_m = (bus_wr && aidx == OFF_ENSET) ? bus_wdata[NUM_SRC-1:0] : '0;
  assign clr_m = (bus_wr && aidx == OFF_ENCLR) ? bus_wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | set_m) & ~clr_m;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prio_q <= '0;
    else if (bus_wr) begin
      for (int n = 0; n < NUM_SRC; n++) begin
        if (aidx == OFF_PRIO0 + fld_word(n, SPW))
          prio_q[n] <= bus_wdata[fld_lsb(n, SPW, PRIO_W) +: PRIO_W];
      end
    end
  end

  // pack the priority fields back into readable words
  for (genvar w = 0; w < NUM_PWORD; w++) begin : g_word
    for (genvar k = 0; k < SPW; k++) begin : g_fld
      if (w * SPW + k < NUM_SRC) begin : g_used
        assign pword[w][k*PRIO_W +: PRIO_W] = prio_q[w*SPW + k];
      end else begin : g_pad
        assign pword[w][k*PRIO_W +: PRIO_W] = '0;
      end
    end
  end

  always_comb begin
    rdata_d = '0;
    if (aidx == OFF_ENSET || aidx == OFF_ENCLR) rdata_d = DATA_W'(en_q);
    else if (aidx == OFF_RAW)                   rdata_d = DATA_W'(src_i);
    else if (aidx == OFF_REQ)                   rdata_d = DATA_W'(req_i);
    else begin
      for (int w = 0; w < NUM_PWORD; w++)
        if (aidx == OFF_PRIO0 + w) rdata_d = pword[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign en_o    = en_q;
  assign prio_o  = prio_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/pimc_reqgen.sv
module pimc_reqgen #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4
) (
  input  logic [NUM_SRC-1:0]             src_i,
  input  logic [NUM_SRC-1:0]             en_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic [NUM_SRC-1:0]             req_o
);
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_req
    assign req_o[n] = src_i[n] & en_i[n] & (|prio_i[n]);
  end
endmodule

// File: rtl/pimc_arb.sv
module pimc_arb #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]             req_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic [PRIO_W-1:0]              best_lvl_o,
  output logic [ID_W-1:0]                best_id_o
);
  // strict compare: an equal priority at a higher index never displaces
  always_comb begin
    best_lvl_o = '0;
    best_id_o  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i] && prio_i[i] > best_lvl_o) begin
        best_lvl_o = prio_i[i];
        best_id_o  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/pimc_top.sv
module pimc_top #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [PRIO_W-1:0]  irq_level,
  output logic [ID_W-1:0]    irq_src
);
  logic [NUM_SRC-1:0]             en_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]             req_w;
  logic [PRIO_W-1:0]              best_lvl;
  logic [ID_W-1:0]                best_id;
  logic [PRIO_W-1:0]              lvl_q;
  logic [ID_W-1:0]                id_q;

  pimc_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .src_i(src_i), .req_i(req_w),
    .en_o(en_q), .prio_o(prio_q), .rdata_o(bus_rdata)
  );

  pimc_reqgen #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_reqgen (
    .src_i(src_i), .en_i(en_q), .prio_i(prio_q), .req_o(req_w)
  );

  pimc_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .req_i(req_w), .prio_i(prio_q), .best_lvl_o(best_lvl), .best_id_o(best_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      id_q  <= '0;
    end else begin
      lvl_q <= best_lvl;
      id_q  <= best_id;
    end
  end

  assign irq_level = lvl_q;
  assign irq_src   = id_q;
endmodule

// File: rtl/pimc_chk.sv
module pimc_chk #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_wr,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [DATA_W-1:0]              bus_wdata,
  input logic [NUM_SRC-1:0]             en_q,
  input logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q,
  input logic [NUM_SRC-1:0]             req_w,
  input logic [PRIO_W-1:0]              irq_level,
  input logic [ID_W-1:0]                irq_src
);
  logic [NUM_SRC-1:0]             req_d;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_d  <= '0;
      prio_d <= '0;
    end else begin
      req_d  <= req_w;
      prio_d <= prio_q;
    end
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && int'(bus_addr) == 0) |=>
      ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && int'(bus_addr) == 1) |=> ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

  p_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && int'(bus_addr) <= 1) |=> $stable(en_q));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_d == '0) |-> (irq_level == '0));

  p_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (req_d[irq_src] && prio_d[irq_src] == irq_level));

  p_nosrc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) |-> (irq_src == '0));
endmodule

bind pimc_top pimc_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .en_q(en_q), .prio_q(prio_q), .req_w(req_w), .irq_level(irq_level), .irq_src(irq_src)
);

// File: tb/test_pimc_top.sv
module test_pimc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src = '0;
  logic [3:0]  irq_level;
  logic [4:0]  irq_src;

  always #5 clk = ~clk;

  pimc_top i_pimc_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src),
    .irq_level(irq_level), .irq_src(irq_src)
  );

  typedef struct { string tag; logic [31:0] val; } item_t;
  item_t       exp_q[$];
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;
  logic        rd_seen = 1'b0;
  logic [31:0] en_m = '0;
  logic [3:0]  prio_m [32];

  initial for (int i = 0; i < 32; i++) prio_m[i] = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed read
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("monitor underflow", 32'h1, 32'h0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        check(it.tag, bus_rdata, it.val);
      end
    end
  end

  function automatic logic [31:0] model_req();
    logic [31:0] r;
    for (int n = 0; n < 32; n++) r[n] = src[n] & en_m[n] & (prio_m[n] != 0);
    return r;
  endfunction

  // search from the top priority down; first hit at the lowest index wins
  function automatic logic [8:0] model_win();
    for (int p = 15; p >= 1; p--)
      for (int n = 0; n < 32; n++)
        if (src[n] && en_m[n] && prio_m[n] == p[3:0]) return {p[3:0], n[4:0]};
    return '0;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[3:0]; bus_wdata = d;
    if (a == 0) en_m = en_m | d;
    else if (a == 1) en_m = en_m & ~d;
    else if (a >= 4 && a <= 7)
      for (int k = 0; k < 8; k++) prio_m[(a-4)*8 + k] = d[4*k +: 4];
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a[3:0];
    it.tag = tag; it.val = exp;
    exp_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_lvl(input string tag);
    logic [8:0] w;
    @(negedge clk);
    w = model_win();
    check({tag, " level"}, 32'(irq_level), 32'(w[8:5]));
    check({tag, " source"}, 32'(irq_src), 32'(w[4:0]));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 level after reset", 32'(irq_level), 0);
    check("R1 source after reset", 32'(irq_src), 0);
    rd(0, 0, "R1 enable reset");
    rd(4, 0, "R1 prio word0 reset");
    rd(7, 0, "R1 prio word3 reset");
    // R2 set, R4 readback
    wr(0, 32'h0000_0005);
    wr(0, 32'h0000_0100);
    rd(0, 32'h0000_0105, "R2 set accumulates");
    rd(1, 32'h0000_0105, "R4 enable via clear offset");
    // R3 partial clear
    wr(1, 32'h0000_0001);
    rd(0, 32'h0000_0104, "R3 single clear");
    // R5 priorities: src2=3, src8=7
    wr(4, 32'h0000_0300);
    wr(5, 32'h0000_0007);
    rd(4, 32'h0000_0300, "R5 word0 readback");
    rd(5, 32'h0000_0007, "R5 word1 readback");
    // R6 raw and request, R7 level
    src = 32'h0000_0104;
    rd(2, 32'h0000_0104, "R6 raw sources");
    rd(3, model_req(), "R6 request vector");
    chk_lvl("R7 max of two");
    // R8 tie: src9,src10 at 7, src8 drops to 2
    wr(0, 32'h0000_0600);
    wr(5, 32'h0000_0772);
    src = 32'h0000_0704;
    chk_lvl("R8 tie lowest index");
    check("R8 tie picks source 9", 32'(irq_src), 9);
    // R9 zero priority never requests
    wr(0, 32'h0010_0000);
    src = src | 32'h0010_0000;
    rd(3, model_req(), "R9 zero prio not requested");
    chk_lvl("R9 level unchanged");
    // R10 level follows sources
    src[9] = 1'b0;
    chk_lvl("R10 drop src9");
    check("R10 winner now 10", 32'(irq_src), 10);
    src[10] = 1'b0;
    chk_lvl("R10 drop src10");
    check("R10 winner now src2 level 3", 32'(irq_level), 3);
    src[10] = 1'b1;
    chk_lvl("R10 reassert src10");
    // R11 writes to read-only and unmapped offsets
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    wr(9, 32'hFFFF_FFFF);
    wr(15, 32'h0000_0000);
    rd(0, en_m, "R11 enables untouched");
    rd(4, 32'h0000_0300, "R11 prio untouched");
    rd(9, 0, "R11 unmapped read zero");
    chk_lvl("R11 level untouched");
    // R5 top source boundary
    wr(7, 32'hF000_0000);
    wr(0, 32'h8000_0000);
    src[31] = 1'b1;
    chk_lvl("R5 source 31 prio 15");
    check("R5 level 15", 32'(irq_level), 15);
    // R3 mask all
    wr(1, 32'hFFFF_FFFF);
    rd(1, 0, "R3 clear all");
    chk_lvl("R3 no level after clear all");
    // random rounds, R7 and R8
    for (int r = 0; r < 12; r++) begin
      for (int w = 4; w < 8; w++) wr(w, $urandom());
      wr(0, $urandom());
      wr(1, $urandom() & $urandom());
      src = $urandom();
      rd(3, model_req(), "R6 random request");
      chk_lvl("R7 R8 random");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule